// File: doc/BRIEF.md
# Double-Buffered Scanline Pixel Streamer

This block produces a monochrome raster for a 640x480 display at one pixel per
clock, with active-low horizontal and vertical sync, a display-enable flag and a
single pixel bit. Pixel data does not come from a frame store. Two scanline
buffers take turns: while one is shifted out during the visible part of a line,
an external writer, such as a DMA engine, loads the other one with 32-bit words
of packed 1-bit pixels. The writer then strobes a done signal that marks that
buffer as full.

The block owns the raster counters. At the last visible pixel of every visible
line it pulses a request that names the buffer it has just finished with. That
buffer is next shown two lines later, so the writer always works one line ahead.
Visible line n is read from buffer n mod 2. When a line begins and its buffer is
not marked full, the whole line is shown black, with display-enable still high.
A sticky error flag is raised and a saturating counter advances. Sync timing is
not disturbed.

Top module: `scanline_streamer`

## Requirements
- R1: A line is H_ACTIVE+H_FP+H_SYNC+H_BP clocks long (800 by default). hsync_n is 0 for the H_SYNC clocks that begin H_ACTIVE+H_FP clocks after the first visible pixel, and is 1 at all other times.
- R2: A frame is V_ACTIVE+V_FP+V_SYNC+V_BP lines (525 by default). vsync_n is 0 for the whole of lines V_ACTIVE+V_FP through V_ACTIVE+V_FP+V_SYNC-1, counted from 0 at the first visible line, and is 1 otherwise.
- R3: de is 1 exactly for the first H_ACTIVE clocks of each of the first V_ACTIVE lines. pix is 0 whenever de is 0.
- R4: On a played line n, pixel h is bit WORD_W-1-(h mod WORD_W) of word h/WORD_W in buffer n mod 2, so each word is shown from its most significant bit first.
- R5: line_req is 1 for one clock, in the same clock as the last visible pixel of each visible line. In that clock line_req_buf equals the line number mod 2. If that line was played, its buffer stops being marked full.
- R6: A clock with wr_en high stores wr_data at word wr_addr of buffer wr_buf. A clock with wr_done high marks buffer wr_buf full, and this takes priority over a release of the same buffer in the same clock.
- R7: If the buffer of a visible line is not marked full in the clock before that line's first pixel is output, pix is 0 for the whole line. The buffer's full mark is left unchanged, and hsync_n, vsync_n and de keep their normal timing.
- R8: underrun becomes 1 in the clock that shows the first pixel of an underrun line. It returns to 0 one clock after udr_clr is sampled high. A detection in the same clock as udr_clr leaves it at 1.
- R9: underrun_cnt rises by one for each underrun line, holds at its all-ones value, and is cleared only by reset.
- R10: While rst_n is low, hsync_n and vsync_n are 1 and de, pix, line_req, underrun and underrun_cnt are 0. After rst_n rises, the third clock edge outputs position line 0, pixel 0. From then on all outputs describe the same raster position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchronizer |
| wr_en | input | 1 | Store one word into a line buffer |
| wr_buf | input | 1 | Buffer addressed by wr_en and wr_done |
| wr_addr | input | AW (5) | Word index inside the buffer |
| wr_data | input | WORD_W (32) | Packed pixels, first pixel in the MSB |
| wr_done | input | 1 | Mark buffer wr_buf full |
| udr_clr | input | 1 | Clear the sticky underrun flag |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| de | output | 1 | Visible-region flag |
| pix | output | 1 | Pixel bit |
| line_req | output | 1 | One-clock request to refill a buffer |
| line_req_buf | output | 1 | Buffer named by line_req |
| underrun | output | 1 | Sticky underrun flag |
| underrun_cnt | output | CNT_W (8) | Saturating count of underrun lines |

## Verification
The two functions that can meet in one clock are the underrun detection at a line start and a software clear of the sticky flag. The stimulus stalls the writer for three whole frames, so every line start finds an empty buffer, and drives udr_clr on exactly those line-start edges. The bench judges that the flag stays at 1 and that the counter still advances until it saturates. Random clears elsewhere show that the flag drops one clock later. The same stall period, mixed with randomly late fills, is used to check that sync and enable timing carry on across blanked lines and that played lines resume as soon as their buffers are refilled.

// File: rtl/sst_pkg.sv
package sst_pkg;

  // Decoded raster position shared between timing, control and output stage
  typedef struct packed {
    logic active;      // inside visible columns and visible lines
    logic line_start;  // first pixel of a visible line
    logic act_end;     // last pixel of a visible line
    logic hsync;       // horizontal sync interval (active high here)
    logic vsync;       // vertical sync interval (active high here)
    logic buf_sel;     // buffer owned by the current line
  } sst_pos_t;

endpackage

// File: rtl/sst_timing.sv
module sst_timing import sst_pkg::*; #(
  parameter int H_ACTIVE = 640,
  parameter int H_FP     = 16,
  parameter int H_SYNC   = 96,
  parameter int H_BP     = 48,
  parameter int V_ACTIVE = 480,
  parameter int V_FP     = 10,
  parameter int V_SYNC   = 2,
  parameter int V_BP     = 33,
  parameter int HW       = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  output sst_pos_t      pos_o,
  output logic [HW-1:0] h_o
);

  localparam int H_TOTAL = H_ACTIVE + H_FP + H_SYNC + H_BP;
  localparam int V_TOTAL = V_ACTIVE + V_FP + V_SYNC + V_BP;
  localparam int VW      = $clog2(V_TOTAL);

  localparam logic [HW-1:0] H_LAST  = HW'(H_TOTAL - 1);
  localparam logic [HW-1:0] H_VIS   = HW'(H_ACTIVE);
  localparam logic [HW-1:0] H_SBEG  = HW'(H_ACTIVE + H_FP);
  localparam logic [HW-1:0] H_SEND  = HW'(H_ACTIVE + H_FP + H_SYNC);
  localparam logic [HW-1:0] H_AEND  = HW'(H_ACTIVE - 1);
  localparam logic [VW-1:0] V_LAST  = VW'(V_TOTAL - 1);
  localparam logic [VW-1:0] V_VIS   = VW'(V_ACTIVE);
  localparam logic [VW-1:0] V_SBEG  = VW'(V_ACTIVE + V_FP);
  localparam logic [VW-1:0] V_SEND  = VW'(V_ACTIVE + V_FP + V_SYNC);

  logic [HW-1:0] h_q, h_d;
  logic [VW-1:0] v_q, v_d;
  logic          line_wrap;

  // next-state
  always_comb begin
    line_wrap = (h_q == H_LAST);
    h_d       = line_wrap ? '0 : h_q + 1'b1;
    v_d       = v_q;
    if (line_wrap) begin
      v_d = (v_q == V_LAST) ? '0 : v_q + 1'b1;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_q <= '0;
      v_q <= '0;
    end else begin
      h_q <= h_d;
      v_q <= v_d;
    end
  end

  // position decode
  logic v_vis;
  always_comb begin
    v_vis            = (v_q < V_VIS);
    pos_o.active     = v_vis && (h_q < H_VIS);
    pos_o.line_start = v_vis && (h_q == '0);
    pos_o.act_end    = v_vis && (h_q == H_AEND);
    pos_o.hsync      = (h_q >= H_SBEG) && (h_q < H_SEND);
    pos_o.vsync      = (v_q >= V_SBEG) && (v_q < V_SEND);
    pos_o.buf_sel    = v_q[0];
  end

  assign h_o = h_q;

  AST_H_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (h_q == H_LAST) |=> (h_q == '0)); // R1

  AST_V_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (h_q != H_LAST) |=> $stable(v_q)); // R2

endmodule

// File: rtl/sst_linebuf.sv
module sst_linebuf #(
  parameter int WORD_W = 32,
  parameter int WORDS  = 20,
  parameter int AW     = 5,
  parameter int IW     = 5,
  parameter int BW     = 5
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic              wr_buf,
  input  logic [AW-1:0]     wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_buf,
  input  logic [IW-1:0]     rd_word,
  input  logic [BW-1:0]     rd_bit,
  output logic              bit_o
);

  logic [WORD_W-1:0] rd_w [2];
  logic              rd_in_range;
  logic [AW-1:0]     rd_sel;

  assign rd_in_range = (int'(rd_word) < WORDS);
  assign rd_sel      = rd_word[AW-1:0];

  for (genvar g = 0; g < 2; g++) begin : g_buf
    logic [WORD_W-1:0] mem [WORDS];
    logic              we;

    assign we = wr_en && (wr_buf == 1'(g)) && (int'(wr_addr) < WORDS);

    // storage carries no reset; contents are only used once marked full
    always_ff @(posedge clk) begin
      if (we) begin
        mem[wr_addr] <= wr_data;
      end
    end

    assign rd_w[g] = rd_in_range ? mem[rd_sel] : '0;
  end

  // WORD_W is a power of two, so inverting the bit offset selects MSB first
  logic [WORD_W-1:0] sel_w;
  assign sel_w = rd_buf ? rd_w[1] : rd_w[0];
  assign bit_o = sel_w[~rd_bit];

endmodule

// File: rtl/sst_ctrl.sv
module sst_ctrl #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_start,
  input  logic             act_end,
  input  logic             buf_sel,
  input  logic             wr_done,
  input  logic             wr_buf,
  input  logic             clr,
  output logic             play_o,
  output logic             udr_det_o,
  output logic             req_o,
  output logic             req_buf_o,
  output logic             flag_o,
  output logic [CNT_W-1:0] cnt_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [1:0]       full_q, full_d;
  logic             ok_q, ok_d;
  logic             flag_q, flag_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             req_q, req_d;
  logic             rbuf_q, rbuf_d;
  logic             play, det;

  // next-state
  always_comb begin
    play   = line_start ? full_q[buf_sel] : ok_q;
    det    = line_start && !full_q[buf_sel];
    ok_d   = play;

    for (int b = 0; b < 2; b++) begin
      full_d[b] = full_q[b];
      if (act_end && play && (buf_sel == 1'(b))) begin
        full_d[b] = 1'b0;
      end
      if (wr_done && (wr_buf == 1'(b))) begin
        full_d[b] = 1'b1;
      end
    end

    flag_d = flag_q;
    if (clr) begin
      flag_d = 1'b0;
    end
    if (det) begin
      flag_d = 1'b1;
    end

    cnt_d = cnt_q;
    if (det && (cnt_q != CNT_MAX)) begin
      cnt_d = cnt_q + 1'b1;
    end

    req_d  = act_end;
    rbuf_d = act_end ? buf_sel : rbuf_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= '0;
      ok_q   <= 1'b0;
      flag_q <= 1'b0;
      cnt_q  <= '0;
      req_q  <= 1'b0;
      rbuf_q <= 1'b0;
    end else begin
      full_q <= full_d;
      ok_q   <= ok_d;
      flag_q <= flag_d;
      cnt_q  <= cnt_d;
      req_q  <= req_d;
      rbuf_q <= rbuf_d;
    end
  end

  assign play_o    = play;
  assign udr_det_o = det;
  assign req_o     = req_q;
  assign req_buf_o = rbuf_q;
  assign flag_o    = flag_q;
  assign cnt_o     = cnt_q;

  AST_FLAG_ON_DETECT: assert property (@(posedge clk) disable iff (!rst_n)
    det |=> flag_q); // R8

  AST_CNT_NEVER_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cnt_q >= $past(cnt_q))); // R9

  AST_REQ_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |=> !req_q); // R5

  AST_DONE_MARKS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |=> full_q[$past(wr_buf)]); // R6

endmodule

// File: rtl/scanline_streamer.sv
module scanline_streamer import sst_pkg::*; #(
  parameter int H_ACTIVE = 640,
  parameter int H_FP     = 16,
  parameter int H_SYNC   = 96,
  parameter int H_BP     = 48,
  parameter int V_ACTIVE = 480,
  parameter int V_FP     = 10,
  parameter int V_SYNC   = 2,
  parameter int V_BP     = 33,
  parameter int WORD_W   = 32,
  parameter int CNT_W    = 8,
  parameter int WORDS    = H_ACTIVE / WORD_W,
  parameter int AW       = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_buf,
  input  logic [AW-1:0]     wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              wr_done,
  input  logic              udr_clr,
  output logic              hsync_n,
  output logic              vsync_n,
  output logic              de,
  output logic              pix,
  output logic              line_req,
  output logic              line_req_buf,
  output logic              underrun,
  output logic [CNT_W-1:0]  underrun_cnt
);

  localparam int H_TOTAL = H_ACTIVE + H_FP + H_SYNC + H_BP;
  localparam int HW      = $clog2(H_TOTAL);
  localparam int BW      = $clog2(WORD_W);
  localparam int IW      = HW - BW;

  // reset: asserted at once, released after two clock edges
  logic rs_meta, rs_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      rs_n    <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      rs_n    <= rs_meta;
    end
  end

  sst_pos_t      pos;
  logic [HW-1:0] h_cnt;

  sst_timing #(
    .H_ACTIVE(H_ACTIVE), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_ACTIVE(V_ACTIVE), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP),
    .HW(HW)
  ) u_timing (
    .clk   (clk),
    .rst_n (rs_n),
    .pos_o (pos),
    .h_o   (h_cnt)
  );

  logic play, udr_det;

  sst_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rs_n),
    .line_start (pos.line_start),
    .act_end    (pos.act_end),
    .buf_sel    (pos.buf_sel),
    .wr_done    (wr_done),
    .wr_buf     (wr_buf),
    .clr        (udr_clr),
    .play_o     (play),
    .udr_det_o  (udr_det),
    .req_o      (line_req),
    .req_buf_o  (line_req_buf),
    .flag_o     (underrun),
    .cnt_o      (underrun_cnt)
  );

  logic buf_bit;

  sst_linebuf #(
    .WORD_W(WORD_W), .WORDS(WORDS), .AW(AW), .IW(IW), .BW(BW)
  ) u_lbuf (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_buf  (wr_buf),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_buf  (pos.buf_sel),
    .rd_word (h_cnt[HW-1:BW]),
    .rd_bit  (h_cnt[BW-1:0]),
    .bit_o   (buf_bit)
  );

  // output stage: one register per output, all for the same position
  logic hs_d, vs_d, de_d, pix_d;
  logic hs_q, vs_q, de_q, pix_q;

  always_comb begin
    hs_d  = !pos.hsync;
    vs_d  = !pos.vsync;
    de_d  = pos.active;
    pix_d = pos.active && play && buf_bit;
  end

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) begin
      hs_q  <= 1'b1;
      vs_q  <= 1'b1;
      de_q  <= 1'b0;
      pix_q <= 1'b0;
    end else begin
      hs_q  <= hs_d;
      vs_q  <= vs_d;
      de_q  <= de_d;
      pix_q <= pix_d;
    end
  end

  assign hsync_n = hs_q;
  assign vsync_n = vs_q;
  assign de      = de_q;
  assign pix     = pix_q;

  AST_BLANK_ON_UNDERRUN: assert property (@(posedge clk) disable iff (!rs_n)
    udr_det |=> !pix_q); // R7

  AST_NO_DE_IN_HSYNC: assert property (@(posedge clk) disable iff (!rs_n)
    !hs_q |-> !de_q); // R1

  AST_REQ_AT_LAST_PIXEL: assert property (@(posedge clk) disable iff (!rs_n)
    line_req |-> de_q); // R5

endmodule

// File: tb/scanline_streamer_tb.sv
`timescale 1ns/1ps
module scanline_streamer_tb;

  localparam int HA = 64, HFP = 4, HS = 8, HBP = 4;
  localparam int VA = 6, VFP = 2, VS = 2, VBP = 2;
  localparam int WW = 32, CW = 4;
  localparam int WORDS = HA / WW;
  localparam int AWB = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam int HT = HA + HFP + HS + HBP;
  localparam int VT = VA + VFP + VS + VBP;
  localparam int FRAMES = 9;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, wr_en, wr_buf, wr_done, udr_clr;
  logic [AWB-1:0] wr_addr;
  logic [WW-1:0]  wr_data;
  logic hsync_n, vsync_n, de, pix, line_req, line_req_buf, underrun;
  logic [CW-1:0] underrun_cnt;

  scanline_streamer #(
    .H_ACTIVE(HA), .H_FP(HFP), .H_SYNC(HS), .H_BP(HBP),
    .V_ACTIVE(VA), .V_FP(VFP), .V_SYNC(VS), .V_BP(VBP),
    .WORD_W(WW), .CNT_W(CW)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_buf(wr_buf),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_done(wr_done),
    .udr_clr(udr_clr), .hsync_n(hsync_n), .vsync_n(vsync_n), .de(de),
    .pix(pix), .line_req(line_req), .line_req_buf(line_req_buf),
    .underrun(underrun), .underrun_cnt(underrun_cnt)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  int cyc    = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h cycle=%0d", tag, act, exp, cyc);
    end
  endtask

  // bench reference state
  logic [WW-1:0] bm [2][WORDS];
  bit  [1:0] mf;
  bit  mok, uflag;
  int  ucnt;
  int  mh, mv, frame;
  // writer stand-in
  bit  [1:0] pend;
  bit  wbusy, wb;
  int  widx, wdel;
  int  coinc;

  function automatic bit exp_hsync_n(int h);
    return !((h >= HA + HFP) && (h < HA + HFP + HS));
  endfunction

  function automatic bit exp_vsync_n(int v);
    return !((v >= VA + VFP) && (v < VA + VFP + VS));
  endfunction

  function automatic bit exp_bit(logic [WW-1:0] w, int h);
    return w[WW-1-(h % WW)];
  endfunction

  initial begin
    bit vis, ls, ae, b, okn, det, e_de, e_pix, e_flag, hold;
    int e_cnt;
    void'($urandom(32'd7031));
    rst_n = 1'b0; wr_en = 1'b0; wr_buf = 1'b0; wr_addr = '0;
    wr_data = '0; wr_done = 1'b0; udr_clr = 1'b0;
    mf = '0; mok = 1'b0; uflag = 1'b0; ucnt = 0; mh = 0; mv = 0; frame = 0;
    pend = '0; wbusy = 1'b0; wb = 1'b0; widx = 0; wdel = 0; coinc = 0;

    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 hsync_n in reset", hsync_n, 1);
    chk("R10 vsync_n in reset", vsync_n, 1);
    chk("R10 de in reset", de, 0);
    chk("R10 pix in reset", pix, 0);
    chk("R10 line_req in reset", line_req, 0);
    chk("R10 underrun in reset", underrun, 0);
    chk("R10 count in reset", underrun_cnt, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R10 two edges after release still idle
    chk("R10 de before start", de, 0);
    chk("R10 hsync_n before start", hsync_n, 1);

    for (int n = 0; n < FRAMES * HT * VT; n++) begin
      @(negedge clk);
      cyc = n;
      vis = (mv < VA);
      ls  = vis && (mh == 0);
      ae  = vis && (mh == HA - 1);
      b   = mv[0];
      okn = ls ? mf[b] : mok;
      det = ls && !mf[b];
      e_de  = vis && (mh < HA);
      e_pix = e_de && okn && exp_bit(bm[b][(mh < HA) ? mh / WW : 0], mh);
      e_flag = det ? 1'b1 : (udr_clr ? 1'b0 : uflag);
      e_cnt  = (det && ucnt != (1 << CW) - 1) ? ucnt + 1 : ucnt;

      chk("R1 hsync_n", hsync_n, exp_hsync_n(mh));
      chk("R2 vsync_n", vsync_n, exp_vsync_n(mv));
      chk("R3 de", de, e_de);
      if (e_de && okn) chk("R4 R6 pixel from buffer", pix, e_pix);
      else             chk("R7 R3 blanked pixel", pix, 0);
      chk("R5 line_req", line_req, ae);
      if (ae) chk("R5 line_req_buf", line_req_buf, b);
      if (det && udr_clr) begin
        coinc++;
        chk("R8 set wins over clear", underrun, 1);
      end else begin
        chk("R8 underrun flag", underrun, e_flag);
      end
      chk("R9 underrun count", underrun_cnt, e_cnt);

      // advance reference with the inputs sampled at the edge just past
      if (wr_en) bm[wr_buf][wr_addr] = wr_data;
      if (ae && okn) mf[b] = 1'b0;
      if (wr_done) mf[wr_buf] = 1'b1;
      if (ae) pend[b] = 1'b1;
      mok = okn; uflag = e_flag; ucnt = e_cnt;
      mh++;
      if (mh == HT) begin
        mh = 0; mv++;
        if (mv == VT) begin mv = 0; frame++; end
      end

      // next inputs
      hold = (frame >= 3) && (frame <= 5);
      wr_en = 1'b0; wr_done = 1'b0; udr_clr = 1'b0;
      if (!wbusy && pend != 0 && !hold) begin
        wb = pend[0] ? 1'b0 : 1'b1;
        pend[wb] = 1'b0;
        wbusy = 1'b1; widx = 0;
        wdel = ($urandom % 7 == 0) ? 130 : int'($urandom % 15);
      end else if (wbusy) begin
        if (wdel > 0) wdel--;
        else if (widx < WORDS) begin
          wr_en = 1'b1; wr_buf = wb; wr_addr = AWB'(widx); wr_data = $urandom;
          widx++;
        end else begin
          wr_done = 1'b1; wr_buf = wb; wbusy = 1'b0;
        end
      end
      if (hold && mh == 0 && mv < VA) udr_clr = 1'b1;   // clear on a detecting edge
      else if ($urandom % 40 == 0) udr_clr = 1'b1;
    end

    chk("R8 coincident clear and detect provoked", (coinc > 0), 1);
    chk("R9 count saturated", underrun_cnt, (1 << CW) - 1);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R10 watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule